// File: doc/BRIEF.md
# Fan Start-up and Stall Supervisor

This block watches over a brushless fan driven by a pulse-width modulator and decides when the modulator may run on its own. It works in whole modulator periods, which a one-cycle period strobe marks. On power-up, or when shutdown is released, it forces the drive fully on so that a stopped fan can spin up. After that it leaves speed control to the modulator and checks that commutation pulses keep arriving. When pulses stop, it runs a fixed sequence of recovery attempts. If none of them brings a pulse back, it holds the drive off and pulls a fault line low until software or hardware steps in.

The tachometer or commutation pulse arrives asynchronously. It is synchronised with two flops, and only its rising edge counts. An edge that arrives in the cycle the drive switches on, or in a programmable number of clocks after that, is discarded. This removes the current spike caused by switching on the drive. Shutdown comes from two comparator levels: one that asserts it and a higher one that releases it, which gives hysteresis. Leaving shutdown is the only way, other than power-on reset, to clear a latched fault. While the fan is running normally, an over-temperature flag from the modulator also pulls the fault line low.

Top module: `fan_supervisor`

## Requirements
- R1: After reset, or on leaving shutdown, `force_on` is 1 for START_PERIODS (default 32) period strobes. An accepted pulse during this window moves the block to normal running, where `force_on` and `force_off` are both 0.
- R2: If the first start window ends with no accepted pulse, a second start window of START_PERIODS strobes follows, with `force_on` still 1. If that window also ends with no accepted pulse, the block enters the latched fault state.
- R3: In normal running, every accepted pulse clears a count of period strobes. When MISS_PERIODS (default 32) strobes in a row pass with no accepted pulse, the count times out. A pulse and a strobe in the same cycle count as a pulse.
- R4: On a missing-pulse timeout, `force_on` is 1 for a diagnostic window of DIAG_PERIODS (default 3) strobes. An accepted pulse in this window returns the block to normal running.
- R5: If the diagnostic window ends with no pulse, one retry window of START_PERIODS strobes follows with `force_on` at 1. A pulse in it returns the block to normal running. If the window ends with no pulse, the block enters the latched fault state.
- R6: In the latched fault state, `force_off` is 1, `force_on` is 0 and `fault_n` is 0. The state holds, whatever pulses or strobes arrive.
- R7: Only power-on reset or a shutdown followed by its release leaves the latched fault state. After release, the block restarts at the first start window, exactly as after reset.
- R8: While shutdown is in effect, `force_off` is 1, `force_on` is 0 and `fault_n` is 1, whatever the level of `overtemp`.
- R9: A synchronised pulse edge is ignored if it falls in the cycle where `drive_rise` is 1 or in the BLANK_CLKS (default 4) clocks after that cycle.
- R10: Shutdown takes effect when `shdn_below` is 1. It stays in effect, even after `shdn_below` returns to 0, until `shdn_above` is 1.
- R11: `overtemp` drives `fault_n` low only in normal running. In the start, diagnostic and retry windows it has no effect on the outputs.
- R12: `tach_raw` counts as a pulse only on its rising edge. A level held high counts once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| tach_raw | input | 1 | Asynchronous fan commutation pulse |
| drive_rise | input | 1 | One-cycle flag: the modulator drive turns on |
| period_tick | input | 1 | One-cycle strobe at each modulator period |
| shdn_below | input | 1 | Shutdown-assert comparator: input below the low threshold |
| shdn_above | input | 1 | Shutdown-release comparator: input above the high threshold |
| overtemp | input | 1 | Modulator at full demand (over-temperature) |
| force_on | output | 1 | Forces the drive fully on |
| force_off | output | 1 | Forces the drive off |
| fault_n | output | 1 | Active-low fault indication |

## Verification
The stimulus withholds pulses across the two start windows, then places pulses at different points of the missing-pulse window. A pulse one strobe before timeout tells whether the count is cleared or merely stopped. Pulses are placed inside and after the diagnostic and retry windows, which separates a return to running from a fall into the latched fault. Trains of pulses timed just after each drive rising edge run against the same trains without drive edges, which shows whether blanking rejects them. A tach level held high across a full window shows whether the block uses edge detection or level sensing. Shutdown is exercised with the release comparator low, then high, and with over-temperature set, to show hysteresis and that the fault output is suppressed.

// File: rtl/fansup_pkg.sv
`timescale 1ns/1ps
package fansup_pkg;

    // Sequencer states. ST_START1 is the reset state.
    typedef enum logic [2:0] {
        ST_SHDN,
        ST_START1,
        ST_START2,
        ST_RUN,
        ST_DIAG,
        ST_RETRY,
        ST_FAULT
    } fan_state_e;

endpackage

// File: rtl/fansup_pulse_cond.sv
`timescale 1ns/1ps
// Synchronises the tach input, finds its rising edge and blanks edges
// that fall near a drive turn-on.
module fansup_pulse_cond #(
    parameter int BLANK_CLKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tach_raw,
    input  logic drive_rise,
    output logic pulse_ok
);
    localparam int BW = $clog2(BLANK_CLKS + 2);

    typedef struct packed {
        logic [2:0]    sync;
        logic [BW-1:0] blank;
    } pc_t;

    pc_t pc_d, pc_q;
    logic edge_seen;
    logic blanking;

    always_comb begin
        pc_d      = pc_q;
        pc_d.sync = {pc_q.sync[1:0], tach_raw};
        if (drive_rise) begin
            pc_d.blank = BW'(BLANK_CLKS);
        end else if (pc_q.blank != '0) begin
            pc_d.blank = pc_q.blank - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q <= '0;
        end else begin
            pc_q <= pc_d;
        end
    end

    assign edge_seen = pc_q.sync[1] & ~pc_q.sync[2];
    assign blanking  = drive_rise | (pc_q.blank != '0);
    assign pulse_ok  = edge_seen & ~blanking;

endmodule

// File: rtl/fansup_shdn_hyst.sv
`timescale 1ns/1ps
// Two-level shutdown latch: set by the low comparator, cleared by the high one.
module fansup_shdn_hyst (
    input  logic clk,
    input  logic rst_n,
    input  logic shdn_below,
    input  logic shdn_above,
    output logic shut
);
    logic shut_d, shut_q;

    always_comb begin
        shut_d = shut_q;
        if (shdn_below) begin
            shut_d = 1'b1;
        end else if (shdn_above) begin
            shut_d = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shut_q <= 1'b0;
        end else begin
            shut_q <= shut_d;
        end
    end

    assign shut = shut_q;

endmodule

// File: rtl/fan_supervisor.sv
`timescale 1ns/1ps
module fan_supervisor
    import fansup_pkg::*;
#(
    parameter int START_PERIODS = 32,
    parameter int MISS_PERIODS  = 32,
    parameter int DIAG_PERIODS  = 3,
    parameter int BLANK_CLKS    = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tach_raw,
    input  logic drive_rise,
    input  logic period_tick,
    input  logic shdn_below,
    input  logic shdn_above,
    input  logic overtemp,
    output logic force_on,
    output logic force_off,
    output logic fault_n
);
    localparam int MAXW0 = (START_PERIODS > MISS_PERIODS) ? START_PERIODS : MISS_PERIODS;
    localparam int MAXW  = (MAXW0 > DIAG_PERIODS) ? MAXW0 : DIAG_PERIODS;
    localparam int CW    = $clog2(MAXW + 1);

    localparam logic [CW-1:0] START_LAST = CW'(START_PERIODS);
    localparam logic [CW-1:0] MISS_LAST  = CW'(MISS_PERIODS);
    localparam logic [CW-1:0] DIAG_LAST  = CW'(DIAG_PERIODS);

    typedef struct packed {
        fan_state_e    st;
        logic [CW-1:0] cnt;
    } seq_t;

    seq_t          seq_d, seq_q;
    logic          pulse_ok;
    logic          shut_q;
    logic [CW-1:0] cnt_inc;
    fan_state_e    st_q;
    logic [CW-1:0] cnt_q;

    fansup_pulse_cond #(
        .BLANK_CLKS(BLANK_CLKS)
    ) u_pulse (
        .clk       (clk),
        .rst_n     (rst_n),
        .tach_raw  (tach_raw),
        .drive_rise(drive_rise),
        .pulse_ok  (pulse_ok)
    );

    fansup_shdn_hyst u_hyst (
        .clk       (clk),
        .rst_n     (rst_n),
        .shdn_below(shdn_below),
        .shdn_above(shdn_above),
        .shut      (shut_q)
    );

    assign cnt_inc = seq_q.cnt + 1'b1;

    always_comb begin
        seq_d = seq_q;
        if (shut_q) begin
            seq_d.st  = ST_SHDN;
            seq_d.cnt = '0;
        end else begin
            unique case (seq_q.st)
                ST_SHDN: begin
                    seq_d.st  = ST_START1;
                    seq_d.cnt = '0;
                end
                ST_START1, ST_START2, ST_RETRY: begin
                    if (pulse_ok) begin
                        seq_d.st  = ST_RUN;
                        seq_d.cnt = '0;
                    end else if (period_tick) begin
                        if (cnt_inc == START_LAST) begin
                            seq_d.cnt = '0;
                            seq_d.st  = (seq_q.st == ST_START1) ? ST_START2 : ST_FAULT;
                        end else begin
                            seq_d.cnt = cnt_inc;
                        end
                    end
                end
                ST_RUN: begin
                    if (pulse_ok) begin
                        seq_d.cnt = '0;
                    end else if (period_tick) begin
                        if (cnt_inc == MISS_LAST) begin
                            seq_d.st  = ST_DIAG;
                            seq_d.cnt = '0;
                        end else begin
                            seq_d.cnt = cnt_inc;
                        end
                    end
                end
                ST_DIAG: begin
                    if (pulse_ok) begin
                        seq_d.st  = ST_RUN;
                        seq_d.cnt = '0;
                    end else if (period_tick) begin
                        if (cnt_inc == DIAG_LAST) begin
                            seq_d.st  = ST_RETRY;
                            seq_d.cnt = '0;
                        end else begin
                            seq_d.cnt = cnt_inc;
                        end
                    end
                end
                ST_FAULT: begin
                    seq_d = seq_q;
                end
                default: begin
                    seq_d.st  = ST_SHDN;
                    seq_d.cnt = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.st  <= ST_START1;
            seq_q.cnt <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign st_q  = seq_q.st;
    assign cnt_q = seq_q.cnt;

    assign force_on  = (st_q == ST_START1) || (st_q == ST_START2) ||
                       (st_q == ST_DIAG)   || (st_q == ST_RETRY);
    assign force_off = (st_q == ST_SHDN) || (st_q == ST_FAULT);
    assign fault_n   = !((st_q == ST_FAULT) || ((st_q == ST_RUN) && overtemp));

endmodule

// File: rtl/fansup_chk.sv
`timescale 1ns/1ps
module fansup_chk
    import fansup_pkg::*;
#(
    parameter int CW           = 6,
    parameter int MISS_PERIODS = 32,
    parameter int BLANK_CLKS   = 4
) (
    input logic          clk,
    input logic          rst_n,
    input fan_state_e    st,
    input logic [CW-1:0] cnt,
    input logic          shut,
    input logic          pulse_ok,
    input logic          drive_rise,
    input logic          period_tick,
    input logic          force_on,
    input logic          force_off,
    input logic          fault_n
);
    // R6: the drive is never forced on and off at once
    p_drive_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(force_on && force_off));

    // R6: the latched fault holds until shutdown
    p_fault_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_FAULT && !shut) |=> (st == ST_FAULT && force_off && !fault_n));

    // R8: shutdown drives off and keeps fault inactive
    p_shdn_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        shut |=> (force_off && fault_n && !force_on));

    // R7: release restarts at the first start window
    p_release_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SHDN && !shut) |=> (st == ST_START1 && force_on));

    // R3: an accepted pulse keeps normal running
    p_pulse_keeps_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN && pulse_ok && !shut) |=> (st == ST_RUN));

    // R4: the final missing strobe enters the diagnostic window
    p_diag_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN && !shut && !pulse_ok && period_tick &&
         cnt == CW'(MISS_PERIODS - 1)) |=> (st == ST_DIAG && force_on));

    // R11: fault output is low outside running only in the latched fault
    p_fault_src_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!fault_n && st != ST_RUN) |-> (st == ST_FAULT));

    generate
        if (BLANK_CLKS > 0) begin : g_blank
            // R9: no edge is accepted in the clock after a drive turn-on
            p_blank_after_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
                $past(drive_rise) |-> !pulse_ok);
        end
    endgenerate

endmodule

bind fan_supervisor fansup_chk #(
    .CW          (CW),
    .MISS_PERIODS(MISS_PERIODS),
    .BLANK_CLKS  (BLANK_CLKS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .st         (st_q),
    .cnt        (cnt_q),
    .shut       (shut_q),
    .pulse_ok   (pulse_ok),
    .drive_rise (drive_rise),
    .period_tick(period_tick),
    .force_on   (force_on),
    .force_off  (force_off),
    .fault_n    (fault_n)
);

// File: tb/fan_supervisor_tb.sv
`timescale 1ns/1ps
module fan_supervisor_tb;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tach_raw = 1'b0;
    logic drive_rise = 1'b0;
    logic period_tick = 1'b0;
    logic shdn_below = 1'b0;
    logic shdn_above = 1'b0;
    logic overtemp = 1'b0;
    logic force_on, force_off, fault_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // expected {force_on, force_off, fault_n}
    localparam logic [2:0] O_ON  = 3'b101;
    localparam logic [2:0] O_RUN = 3'b001;
    localparam logic [2:0] O_OT  = 3'b000;
    localparam logic [2:0] O_FLT = 3'b010;
    localparam logic [2:0] O_SHD = 3'b011;

    logic [2:0] exp_q[$];
    string      tag_q[$];

    always #2.5 clk = ~clk;

    fan_supervisor u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .tach_raw   (tach_raw),
        .drive_rise (drive_rise),
        .period_tick(period_tick),
        .shdn_below (shdn_below),
        .shdn_above (shdn_above),
        .overtemp   (overtemp),
        .force_on   (force_on),
        .force_off  (force_off),
        .fault_n    (fault_n)
    );

    // monitor: pops one expectation per falling edge and compares
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            logic [2:0] e;
            string      t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if ({force_on, force_off, fault_n} !== e) begin
                errors++;
                $display("FAIL %s: on/off/fault_n actual %b expected %b",
                         t, {force_on, force_off, fault_n}, e);
            end
        end
    end

    task automatic expect_out(input logic [2:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(negedge clk);
        #1;
    endtask

    task automatic tick_n(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1 period_tick = 1'b1;
            @(posedge clk); #1 period_tick = 1'b0;
        end
    endtask

    task automatic fan_pulse();
        @(posedge clk); #1 tach_raw = 1'b1;
        repeat (3) @(posedge clk);
        #1 tach_raw = 1'b0;
        repeat (3) @(posedge clk);
        #1;
    endtask

    task automatic blanked_pulse();
        @(posedge clk); #1 drive_rise = 1'b1;
        @(posedge clk); #1 drive_rise = 1'b0; tach_raw = 1'b1;
        repeat (2) @(posedge clk);
        #1 tach_raw = 1'b0;
        repeat (6) @(posedge clk);
        #1;
    endtask

    task automatic settle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        settle(4);
        expect_out(O_ON, "R1 reset state forced on");
        @(posedge clk); #1 rst_n = 1'b1;

        // R1, R2: two start windows then latched fault
        tick_n(31);
        expect_out(O_ON, "R1 first window still on");
        tick_n(1);
        expect_out(O_ON, "R2 second window on");
        tick_n(31);
        expect_out(O_ON, "R2 second window before end");
        tick_n(1);
        expect_out(O_FLT, "R2 fault after two windows");

        // R6: fault holds
        fan_pulse();
        tick_n(5);
        expect_out(O_FLT, "R6 fault ignores pulses");

        // R8, R10, R7: shutdown, hysteresis, release
        @(posedge clk); #1 shdn_below = 1'b1;
        settle(3);
        expect_out(O_SHD, "R8 shutdown entered");
        overtemp = 1'b1;
        tick_n(2);
        expect_out(O_SHD, "R8 overtemp masked in shutdown");
        shdn_below = 1'b0;
        settle(4);
        expect_out(O_SHD, "R10 held between thresholds");
        shdn_above = 1'b1;
        settle(3);
        shdn_above = 1'b0;
        expect_out(O_ON, "R7 release restarts start window");
        expect_out(O_ON, "R11 overtemp ignored while forced on");
        overtemp = 1'b0;

        fan_pulse();
        expect_out(O_RUN, "R1 pulse enters running");
        overtemp = 1'b1;
        settle(1);
        expect_out(O_OT, "R11 overtemp in running");
        overtemp = 1'b0;
        settle(1);
        expect_out(O_RUN, "R11 overtemp released");

        // R3, R4: missing pulse window, clear, diagnostic
        tick_n(31);
        expect_out(O_RUN, "R3 before timeout");
        fan_pulse();
        tick_n(31);
        expect_out(O_RUN, "R3 count cleared by pulse");
        tick_n(1);
        expect_out(O_ON, "R4 diagnostic entered");
        tick_n(2);
        expect_out(O_ON, "R4 diagnostic still on");
        fan_pulse();
        expect_out(O_RUN, "R4 pulse returns to running");

        // R5: retry window with pulse
        tick_n(32);
        tick_n(3);
        expect_out(O_ON, "R5 retry window on");
        fan_pulse();
        expect_out(O_RUN, "R5 pulse in retry returns");

        // R5: retry without pulse
        tick_n(32);
        tick_n(3);
        tick_n(31);
        expect_out(O_ON, "R5 retry before end");
        tick_n(1);
        expect_out(O_FLT, "R5 fault after retry");

        // R7: power-on reset clears the latch
        @(posedge clk); #1 rst_n = 1'b0;
        @(posedge clk); #1 rst_n = 1'b1;
        expect_out(O_ON, "R7 reset clears fault");

        // R9: blanked pulses do not keep the fan alive
        fan_pulse();
        for (int i = 0; i < 32; i++) begin
            blanked_pulse();
            tick_n(1);
        end
        expect_out(O_ON, "R9 blanked pulses ignored");
        fan_pulse();
        for (int i = 0; i < 32; i++) begin
            fan_pulse();
            tick_n(1);
        end
        expect_out(O_RUN, "R9 unblanked pulses accepted");

        // R12: held level counts once
        @(posedge clk); #1 tach_raw = 1'b1;
        settle(4);
        tick_n(31);
        expect_out(O_RUN, "R12 edge counted once");
        tick_n(1);
        expect_out(O_ON, "R12 held level times out");
        tach_raw = 1'b0;

        settle(4);
        done = 1'b1;
    end

    initial begin
        for (int i = 0; i < 150000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected completion");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule